// File: doc/BRIEF.md
# Luma Contrast and Brightness Adjuster

This block adjusts the picture level of a stream of 8-bit luma samples. Each sample arrives with a valid strobe. The block first removes the nominal black level of 16, so black becomes zero. It then multiplies the result by a contrast gain taken from a 6-bit code, where the gain is the code divided by 32. After that it adds a signed brightness offset. The result is clamped below at zero and above at the largest output code.

The output is 10 bits wide. The two lowest bits are a fraction, so one input step equals four output codes. The datapath accepts one sample per clock and has two register stages: the first forms the product, the second adds the offset and clamps.

The contrast and brightness inputs are sampled only on a line-start pulse. Settings cannot change partway through a line.

Top module: `luma_gain_offset`

## Requirements
- R1: An input of 16 (black) with brightness 0 produces output 0 for every contrast code.
- R2: The output before clamping is floor((Y − 16) · C / 8) + 4 · B, where Y is the input, C is the contrast code (0..63, gain C/32) and B is the brightness. The division by 8 rounds toward minus infinity.
- R3: Contrast code 32 is exact unity gain: with B = 0 and Y ≥ 16, the output is (Y − 16) · 4.
- R4: Brightness is a 9-bit two's complement value (−256..255). One brightness step is one integer output step (4 codes), and it is added after the gain.
- R5: A negative sum after the brightness addition gives output 0.
- R6: A sum above 1023 gives output 1023.
- R7: A sample presented with in_valid at clock edge k appears on out_luma, with out_valid high, after edge k+2. Back-to-back samples are accepted on every clock.
- R8: Contrast and brightness are loaded only at an edge where line_start is high. A sample in that same cycle still uses the previous settings. After reset the settings are contrast 32 and brightness 0.
- R9: After reset, out_valid and out_luma are 0. When no result is produced, out_valid is 0 and out_luma holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Pulse that loads new contrast and brightness settings |
| contrast_in | input | 6 | Contrast code, gain = code/32 |
| bright_in | input | 9 | Signed brightness offset in integer output steps |
| in_valid | input | 1 | Marks in_luma as a sample |
| in_luma | input | 8 | Luma sample with black at 16 |
| out_valid | output | 1 | Marks out_luma as a new result |
| out_luma | output | 10 | Adjusted luma, two fractional bits |

## Verification
Unity gain with zero offset is applied to black, mid-grey and peak white, which separates the black subtraction from the scaling. Contrast codes 0, 17, 48 and 63 distinguish a gain of code/32 from other scalings, and code 17 also tests the floor rounding of fractions. Positive and negative offsets on inputs both below and above black show whether the offset is added before or after the gain and clamp. Offset values at the top of the range separate the exact largest in-range code from true saturation. A back-to-back stream and a line-start pulse that coincides with a sample expose any latency or settings-timing error of one cycle.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
   typedef enum logic [1:0] {
      CLIP_PASS = 2'd0,
      CLIP_LOW  = 2'd1,
      CLIP_HIGH = 2'd2
   } clip_e;
endpackage

// File: rtl/lcb_ctl_hold.sv
module lcb_ctl_hold #(
   parameter int CODE_W  = 6,
   parameter int BRT_W   = 9,
   parameter int CON_RST = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] con_in,
   input  logic [BRT_W-1:0]  brt_in,
   output logic [CODE_W-1:0] con_q,
   output logic [BRT_W-1:0]  brt_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         con_q <= CODE_W'(CON_RST);
         brt_q <= '0;
      end else if (load) begin
         con_q <= con_in;
         brt_q <= brt_in;
      end
   end
endmodule

// File: rtl/lcb_mul_stage.sv
module lcb_mul_stage #(
   parameter int IN_W   = 8,
   parameter int CODE_W = 6,
   parameter int BRT_W  = 9,
   parameter int BLACK  = 16,
   localparam int PROD_W = IN_W + CODE_W + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_i,
   input  logic [IN_W-1:0]          luma_i,
   input  logic [CODE_W-1:0]        con_i,
   input  logic [BRT_W-1:0]         brt_i,
   output logic                     vld_o,
   output logic signed [PROD_W-1:0] prod_o,
   output logic [BRT_W-1:0]         brt_o
);
   logic signed [IN_W:0]     lift;
   logic signed [CODE_W:0]   gain;
   logic signed [PROD_W-1:0] prod;

   assign lift = $signed({1'b0, luma_i}) - $signed((IN_W+1)'(BLACK));
   assign gain = $signed({1'b0, con_i});
   assign prod = PROD_W'(lift) * PROD_W'(gain);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         prod_o <= '0;
         brt_o  <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            prod_o <= prod;
            brt_o  <= brt_i;
         end
      end
   end
endmodule

// File: rtl/lcb_sum_clip.sv
module lcb_sum_clip
   import lcb_pkg::*;
#(
   parameter int PROD_W = 16,
   parameter int BRT_W  = 9,
   parameter int CODE_W = 6,
   parameter int FRAC_W = 2,
   parameter int OUT_W  = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_i,
   input  logic signed [PROD_W-1:0] prod_i,
   input  logic [BRT_W-1:0]         brt_i,
   output logic                     vld_o,
   output logic [OUT_W-1:0]         luma_o
);
   localparam int SH     = CODE_W - 1 - FRAC_W;
   localparam int WIDE_A = PROD_W + FRAC_W + 2;
   localparam int WIDE_B = BRT_W + FRAC_W + 1;
   localparam int SUM_W  = ((WIDE_A > WIDE_B) ? WIDE_A : WIDE_B) + 1;

   logic signed [SUM_W-1:0] prod_ext, scaled, offs, sum;
   clip_e                   cls;

   assign prod_ext = {{(SUM_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
   assign offs     = {{(SUM_W-BRT_W-FRAC_W){brt_i[BRT_W-1]}}, brt_i, {FRAC_W{1'b0}}};

   generate
      if (SH >= 0) begin : g_shr
         assign scaled = prod_ext >>> SH;
      end else begin : g_shl
         assign scaled = prod_ext <<< (-SH);
      end
   endgenerate

   assign sum = scaled + offs;

   always_comb begin
      if (sum[SUM_W-1])
         cls = CLIP_LOW;
      else if (|sum[SUM_W-2:OUT_W])
         cls = CLIP_HIGH;
      else
         cls = CLIP_PASS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         luma_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            unique case (cls)
               CLIP_LOW:  luma_o <= '0;
               CLIP_HIGH: luma_o <= '1;
               default:   luma_o <= sum[OUT_W-1:0];
            endcase
         end
      end
   end
endmodule

// File: rtl/luma_gain_offset.sv
module luma_gain_offset #(
   parameter int IN_W    = 8,
   parameter int CODE_W  = 6,
   parameter int BRT_W   = 9,
   parameter int FRAC_W  = 2,
   parameter int BLACK   = 16,
   parameter int CON_RST = 32,
   localparam int OUT_W  = IN_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [CODE_W-1:0] contrast_in,
   input  logic [BRT_W-1:0]  bright_in,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_luma,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_luma
);
   localparam int PROD_W = IN_W + CODE_W + 2;

   generate
      if (FRAC_W < 1 || FRAC_W > CODE_W + 2) begin : g_bad_frac
         $error("luma_gain_offset: FRAC_W out of range");
      end
      if (BLACK < 0 || BLACK >= (1 << IN_W)) begin : g_bad_black
         $error("luma_gain_offset: BLACK outside input range");
      end
      if (CON_RST < 0 || CON_RST >= (1 << CODE_W)) begin : g_bad_rst
         $error("luma_gain_offset: CON_RST outside code range");
      end
      if (CODE_W < 2 || BRT_W < 2) begin : g_bad_w
         $error("luma_gain_offset: widths too small");
      end
   endgenerate

   logic [CODE_W-1:0]        con_act;
   logic [BRT_W-1:0]         brt_act;
   logic                     vld_s1;
   logic signed [PROD_W-1:0] prod_s1;
   logic [BRT_W-1:0]         brt_s1;

   lcb_ctl_hold #(
      .CODE_W (CODE_W),
      .BRT_W  (BRT_W),
      .CON_RST(CON_RST)
   ) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (line_start),
      .con_in(contrast_in),
      .brt_in(bright_in),
      .con_q (con_act),
      .brt_q (brt_act)
   );

   lcb_mul_stage #(
      .IN_W  (IN_W),
      .CODE_W(CODE_W),
      .BRT_W (BRT_W),
      .BLACK (BLACK)
   ) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (in_valid),
      .luma_i(in_luma),
      .con_i (con_act),
      .brt_i (brt_act),
      .vld_o (vld_s1),
      .prod_o(prod_s1),
      .brt_o (brt_s1)
   );

   lcb_sum_clip #(
      .PROD_W(PROD_W),
      .BRT_W (BRT_W),
      .CODE_W(CODE_W),
      .FRAC_W(FRAC_W),
      .OUT_W (OUT_W)
   ) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (vld_s1),
      .prod_i(prod_s1),
      .brt_i (brt_s1),
      .vld_o (out_valid),
      .luma_o(out_luma)
   );
endmodule

// File: rtl/lcb_checker.sv
module lcb_checker #(
   parameter int IN_W   = 8,
   parameter int CODE_W = 6,
   parameter int BRT_W  = 9,
   parameter int FRAC_W = 2,
   parameter int BLACK  = 16,
   localparam int OUT_W = IN_W + FRAC_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_start,
   input logic              in_valid,
   input logic [IN_W-1:0]   in_luma,
   input logic [CODE_W-1:0] con_act,
   input logic [BRT_W-1:0]  brt_act,
   input logic              out_valid,
   input logic [OUT_W-1:0]  out_luma
);
   localparam logic [CODE_W-1:0] UNITY = CODE_W'(1 << (CODE_W - 1));

   logic [OUT_W-1:0] unity_ref;
   assign unity_ref = {in_luma - IN_W'(BLACK), {FRAC_W{1'b0}}};

   AST_BLACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_luma == IN_W'(BLACK) && brt_act == '0) |-> ##2 (out_valid && out_luma == '0)); // R1

   AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && con_act == UNITY && brt_act == '0 && in_luma >= IN_W'(BLACK))
      |-> ##2 (out_luma == $past(unity_ref, 2))); // R3

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid); // R7

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid); // R7

   AST_CTL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> ($stable(con_act) && $stable(brt_act))); // R8

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_luma)); // R9
endmodule

bind luma_gain_offset lcb_checker #(
   .IN_W  (IN_W),
   .CODE_W(CODE_W),
   .BRT_W (BRT_W),
   .FRAC_W(FRAC_W),
   .BLACK (BLACK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_start(line_start),
   .in_valid  (in_valid),
   .in_luma   (in_luma),
   .con_act   (con_act),
   .brt_act   (brt_act),
   .out_valid (out_valid),
   .out_luma  (out_luma)
);

// File: tb/sim_luma_gain_offset.sv
`timescale 1ns/1ps
module sim_luma_gain_offset;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_start = 1'b0;
   logic [5:0] contrast_in = '0;
   logic [8:0] bright_in = '0;
   logic       in_valid = 1'b0;
   logic [7:0] in_luma = '0;
   logic       out_valid;
   logic [9:0] out_luma;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   luma_gain_offset u0 (
      .clk(clk), .rst_n(rst_n), .line_start(line_start),
      .contrast_in(contrast_in), .bright_in(bright_in),
      .in_valid(in_valid), .in_luma(in_luma),
      .out_valid(out_valid), .out_luma(out_luma)
   );

   function automatic int model(int y, int c, int b);
      int s;
      s = (((y - 16) * c) >>> 3) + 4 * b;
      if (s < 0) s = 0;
      if (s > 1023) s = 1023;
      return s;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_ctl(int c, int b);
      contrast_in = 6'(c);
      bright_in   = 9'(b);
      line_start  = 1'b1;
      @(negedge clk);
      line_start  = 1'b0;
   endtask

   task automatic send_chk(string req, int y, int c, int b);
      in_valid = 1'b1;
      in_luma  = 8'(y);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check({req, " valid"}, int'(out_valid), 1);
      check(req, int'(out_luma), model(y, c, b));
   endtask

   task automatic t_reset;
      check("R9 reset valid", int'(out_valid), 0);
      check("R9 reset luma", int'(out_luma), 0);
   endtask

   task automatic t_unity;
      send_chk("R1 black at reset settings", 16, 32, 0);
      send_chk("R3 unity mid", 100, 32, 0);
      check("R3 unity mid literal", int'(out_luma), 336);
      send_chk("R3 unity 235", 235, 32, 0);
      send_chk("R3 unity 255", 255, 32, 0);
   endtask

   task automatic t_gain;
      load_ctl(48, 0);
      send_chk("R2 code48", 116, 48, 0);
      check("R2 code48 literal", int'(out_luma), 600);
      send_chk("R1 black code48", 16, 48, 0);
      load_ctl(0, 0);
      send_chk("R2 code0", 200, 0, 0);
      load_ctl(63, 0);
      send_chk("R2 code63", 80, 63, 0);
      load_ctl(17, 0);
      send_chk("R2 floor code17", 19, 17, 0);
      check("R2 floor literal", int'(out_luma), 6);
   endtask

   task automatic t_bright;
      load_ctl(32, 40);
      send_chk("R4 plus offset on black", 16, 32, 40);
      check("R4 plus literal", int'(out_luma), 160);
      load_ctl(32, -20);
      send_chk("R4 minus offset", 116, 32, -20);
      load_ctl(32, 10);
      send_chk("R4 offset after gain", 10, 32, 10);
      check("R4 after gain literal", int'(out_luma), 16);
   endtask

   task automatic t_negclip;
      load_ctl(32, -100);
      send_chk("R5 negative clip", 50, 32, -100);
      load_ctl(32, 0);
      send_chk("R5 below black", 10, 32, 0);
      load_ctl(32, -256);
      send_chk("R5 most negative offset", 255, 32, -256);
   endtask

   task automatic t_sat;
      load_ctl(63, 0);
      send_chk("R6 gain overflow", 255, 63, 0);
      load_ctl(32, 255);
      send_chk("R6 top no sat", 16, 32, 255);
      check("R6 top literal", int'(out_luma), 1020);
      send_chk("R6 offset overflow", 20, 32, 255);
   endtask

   task automatic t_stream;
      int ys[5] = '{16, 40, 90, 200, 255};
      load_ctl(40, 5);
      for (int i = 0; i <= 5; i++) begin
         if (i < 5) begin
            in_valid = 1'b1;
            in_luma  = 8'(ys[i]);
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
         if (i == 0) check("R7 not early", int'(out_valid), 0);
         if (i >= 1) begin
            check("R7 stream valid", int'(out_valid), 1);
            check("R7 stream data", int'(out_luma), model(ys[i-1], 40, 5));
         end
      end
      @(negedge clk);
      check("R7 valid drops", int'(out_valid), 0);
   endtask

   task automatic t_linestart;
      load_ctl(32, 0);
      contrast_in = 6'd10;
      bright_in   = 9'd50;
      send_chk("R8 ignored without pulse", 100, 32, 0);
      contrast_in = 6'd16;
      bright_in   = 9'd8;
      line_start  = 1'b1;
      in_valid    = 1'b1;
      in_luma     = 8'd100;
      @(negedge clk);
      line_start  = 1'b0;
      in_valid    = 1'b0;
      @(negedge clk);
      check("R8 same-cycle uses old", int'(out_luma), model(100, 32, 0));
      send_chk("R8 new after pulse", 100, 16, 8);
   endtask

   task automatic t_hold;
      logic [9:0] last;
      load_ctl(32, 0);
      send_chk("R9 before hold", 77, 32, 0);
      last = out_luma;
      in_luma = 8'd200;
      repeat (3) @(negedge clk);
      check("R9 hold valid low", int'(out_valid), 0);
      check("R9 hold data", int'(out_luma), int'(last));
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unity();
      t_gain();
      t_bright();
      t_negclip();
      t_sat();
      t_stream();
      t_linestart();
      t_hold();
      finish_run();
   end
endmodule